// File: doc/BRIEF.md
# SMBus Configuration Register File for a Clock Generator

This block is a two-wire SMBus slave that holds the configuration bytes of a multi-output clock generator. It oversamples SCL and SDA on the system clock and decodes START and STOP conditions. It acknowledges one write address and one read address, and it pulls SDA low through an open-drain enable to acknowledge or to send data. Each write transaction carries a command byte whose value is ignored, then a byte count, then data bytes that land in register 0, 1, 2 and onward. A read transaction returns the register count first and then the bytes from register 0 in order.

The stored bytes drive the generator's configuration through a flat output. Byte 0 mixes live pin values into its readback. One stop control is the AND of an active-low pin and a register bit, and that result is also sent out as a run flag. Byte 6 is a fixed signature. The last two bytes can replace the built-in PLL divider values when their select bit is set.

Top module: `smbCfgRegFile`

## Requirements
- R1: The slave acknowledges only the write address 0xD2 and the read address 0xD3. For any other address it returns NACK and leaves SDA released until the next START.
- R2: In a write, the command byte (any value) and the count byte are both acknowledged. Each data byte after them is acknowledged and stored in register 0, then 1, then 2, and so on.
- R3: In the byte 0 readback, bit 1 returns pin freqSel[0] and bit 2 returns pin freqSel[1]. Writes to those bits are ignored. Bit 3 reads as pciStopPinN AND stored bit 3, and the pciRunEff output carries the same AND.
- R4: Byte 6 always reads 0x0D. Writes to it are acknowledged and their data is discarded.
- R5: After reset the stored bytes 0 to 9 are 09, 87, 7F, DF, 3F, 40, 0D, 00, 00, 00 (hex). Bits 4 and 0 of byte 0 are read-only. With both pins low, byte 0 reads 0x01.
- R6: When byte 9 bit 0 is 0, pllN = 48 and pllR = 10. When it is 1, pllN = byte 8 bits 6:0 and pllR = byte 9 bits 6:1.
- R7: Data bytes past register 9 in a write are acknowledged and dropped.
- R8: A read at 0xD3 first returns 0x0A, then register bytes 0, 1, ... in order. Bytes past index 9 read as 0x00. A master NACK ends the read, and the slave then releases SDA.
- R9: A START or STOP in the middle of a byte aborts the transaction. Completed bytes stay written, the partial byte is not written, and the next transaction starts again at register 0.
- R10: The slave changes SDA only while SCL is low. A data byte is committed within four clocks after the SCL rising edge of its eighth bit.
- R11: The cfgBytes output carries stored byte i on bits 8i+7 down to 8i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaDriveLow | output | 1 | Open-drain enable; 1 pulls SDA low |
| freqSel | input | 2 | Frequency-select pins reflected in byte 0 |
| pciStopPinN | input | 1 | Active-low stop pin, combined with byte 0 bit 3 |
| cfgBytes | output | 80 | Stored register bytes, byte i at bits 8i+7:8i |
| pciRunEff | output | 1 | AND of pciStopPinN and stored byte 0 bit 3 |
| pllN | output | 7 | PLL N divider in use |
| pllR | output | 6 | PLL R divider in use |

## Verification
A change of the stop pin can land in the same clock as the write commit of byte 0 bit 3, and both feed pciRunEff and the byte 0 readback. The bench provokes this by toggling the pin while the master clocks the last bit of a byte 0 write. A cycle-by-cycle reference model then judges pciRunEff on every clock once the commit window has passed, and a readback of byte 0 that follows confirms the stored bit together with the live pin value.

// File: rtl/smbCfgPkg.sv
package smbCfgPkg;

  localparam int IDX_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_WR,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } ctrlState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] idx;
    logic [7:0]       data;
  } regStrobe_t;

  function automatic logic [7:0] resetByte(input int i);
    case (i)
      0: return 8'h09;
      1: return 8'h87;
      2: return 8'h7F;
      3: return 8'hDF;
      4: return 8'h3F;
      5: return 8'h40;
      6: return 8'h0D;
      default: return 8'h00;
    endcase
  endfunction

  // bits a bus write may change
  function automatic logic [7:0] wrMask(input int i);
    case (i)
      0: return 8'hE8;
      6: return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/smbCfgCtrl.sv
module smbCfgCtrl
  import smbCfgPkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NREG        = 10,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [7:0]       rdData,
  output logic [IDX_W-1:0] rdIdx,
  output regStrobe_t       strobe,
  output logic             sdaDriveLow
);

  localparam logic [IDX_W-1:0] NREG_L   = IDX_W'(NREG);
  localparam logic [IDX_W-1:0] ONE_L    = IDX_W'(1);
  localparam logic [7:0]       CNT_BYTE = 8'(NREG);

  logic [SYNC_STAGES-1:0] sclSh, sdaSh;
  logic sclPrev, sdaPrev;
  logic sclS, sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSh   <= '1;
      sdaSh   <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSh[0] <= sclIn;
      sdaSh[0] <= sdaIn;
      for (int k = 1; k < SYNC_STAGES; k++) begin
        sclSh[k] <= sclSh[k-1];
        sdaSh[k] <= sdaSh[k-1];
      end
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS = sclSh[SYNC_STAGES-1];
  assign sdaS = sdaSh[SYNC_STAGES-1];

  logic sclRise, sclFall, startDet, stopDet;
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  ctrlState_t       state;
  logic [2:0]       bitCnt;
  logic [7:0]       shReg;
  logic             isRead;
  logic [1:0]       hdrCnt;     // write: 0 cmd, 1 count, 2 data; read: 0 count pending
  logic [IDX_W-1:0] byteIdx;
  logic             ackPh;
  logic             ackDrive;

  logic [7:0]       shNext;
  logic [7:0]       txByte;
  logic [IDX_W-1:0] idxInc;
  logic             doLoad;

  assign shNext = {shReg[6:0], sdaS};
  assign txByte = (hdrCnt == 2'd0) ? CNT_BYTE : rdData;
  assign idxInc = (byteIdx == NREG_L) ? byteIdx : byteIdx + ONE_L;
  assign doLoad = sclFall & ackPh &
                  (((state == ST_ACK) & isRead) | (state == ST_MACK));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      shReg    <= '0;
      isRead   <= 1'b0;
      hdrCnt   <= '0;
      byteIdx  <= '0;
      ackPh    <= 1'b0;
      ackDrive <= 1'b0;
      strobe   <= '0;
    end else begin
      strobe.wrEn <= 1'b0;
      if (startDet) begin
        state    <= ST_ADDR;
        bitCnt   <= '0;
        byteIdx  <= '0;
        hdrCnt   <= '0;
        ackPh    <= 1'b0;
        ackDrive <= 1'b0;
      end else if (stopDet) begin
        state    <= ST_IDLE;
        ackPh    <= 1'b0;
        ackDrive <= 1'b0;
      end else if (doLoad) begin
        shReg    <= txByte;
        bitCnt   <= '0;
        ackPh    <= 1'b0;
        ackDrive <= 1'b0;
        state    <= ST_TX;
        if (hdrCnt == 2'd0) hdrCnt <= 2'd1;
        else                byteIdx <= idxInc;
      end else begin
        case (state)
          ST_ADDR: if (sclRise) begin
            shReg  <= shNext;
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              if (shNext[7:1] == DEV_ADDR) begin
                isRead <= shNext[0];
                ackPh  <= 1'b0;
                state  <= ST_ACK;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          ST_WR: if (sclRise) begin
            shReg  <= shNext;
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              ackPh <= 1'b0;
              state <= ST_ACK;
              if (hdrCnt == 2'd2) begin
                if (byteIdx < NREG_L) begin
                  strobe.wrEn <= 1'b1;
                  strobe.idx  <= byteIdx;
                  strobe.data <= shNext;
                end
                byteIdx <= idxInc;
              end else begin
                hdrCnt <= hdrCnt + 2'd1;
              end
            end
          end
          ST_ACK: if (sclFall) begin
            if (!ackPh) begin
              ackDrive <= 1'b1;
              ackPh    <= 1'b1;
            end else begin
              ackDrive <= 1'b0;
              ackPh    <= 1'b0;
              bitCnt   <= '0;
              state    <= ST_WR;
            end
          end
          ST_TX: if (sclFall) begin
            if (bitCnt == 3'd7) begin
              ackPh <= 1'b0;
              state <= ST_MACK;
            end else begin
              shReg  <= {shReg[6:0], 1'b0};
              bitCnt <= bitCnt + 3'd1;
            end
          end
          ST_MACK: if (sclRise) begin
            if (sdaS) state <= ST_WAIT;
            else      ackPh <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign rdIdx       = byteIdx;
  assign sdaDriveLow = ackDrive | ((state == ST_TX) & ~shReg[7]);

endmodule

// File: rtl/smbCfgRegs.sv
module smbCfgRegs
  import smbCfgPkg::*;
#(
  parameter int         NREG  = 10,
  parameter logic [6:0] DEF_N = 7'd48,
  parameter logic [5:0] DEF_R = 6'd10
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strobe,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic [1:0]       freqSel,
  input  logic             pciStopPinN,
  output logic [7:0]       rdData,
  output logic [NREG*8-1:0] cfgBytes,
  output logic             pciRunEff,
  output logic [6:0]       pllN,
  output logic [5:0]       pllR
);

  logic [NREG-1:0][7:0] regQ;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [7:0] MASK = wrMask(i);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regQ[i] <= resetByte(i);
      end else if (strobe.wrEn && strobe.idx == IDX_W'(i)) begin
        regQ[i] <= (regQ[i] & ~MASK) | (strobe.data & MASK);
      end
    end
  end

  assign pciRunEff = regQ[0][3] & pciStopPinN;

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rdIdx == IDX_W'(i)) rdData = regQ[i];
    end
    if (rdIdx == '0) begin
      rdData[3]   = pciRunEff;
      rdData[2:1] = freqSel;
    end
  end

  logic pllSel;
  assign pllSel   = regQ[9][0];
  assign pllN     = pllSel ? regQ[8][6:0] : DEF_N;
  assign pllR     = pllSel ? regQ[9][6:1] : DEF_R;
  assign cfgBytes = regQ;

endmodule

// File: rtl/smbCfgRegFile.sv
module smbCfgRegFile
  import smbCfgPkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NREG        = 10,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEF_N       = 7'd48,
  parameter logic [5:0] DEF_R       = 6'd10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  input  logic [1:0]        freqSel,
  input  logic              pciStopPinN,
  output logic [NREG*8-1:0] cfgBytes,
  output logic              pciRunEff,
  output logic [6:0]        pllN,
  output logic [5:0]        pllR
);

  regStrobe_t       regStb;
  logic [IDX_W-1:0] rdIdx;
  logic [7:0]       rdData;

  smbCfgCtrl #(
    .DEV_ADDR(DEV_ADDR), .NREG(NREG), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdData(rdData), .rdIdx(rdIdx), .strobe(regStb),
    .sdaDriveLow(sdaDriveLow)
  );

  smbCfgRegs #(
    .NREG(NREG), .DEF_N(DEF_N), .DEF_R(DEF_R)
  ) u_regs (
    .clk(clk), .rstN(rstN), .strobe(regStb), .rdIdx(rdIdx),
    .freqSel(freqSel), .pciStopPinN(pciStopPinN), .rdData(rdData),
    .cfgBytes(cfgBytes), .pciRunEff(pciRunEff), .pllN(pllN), .pllR(pllR)
  );

endmodule

// File: rtl/smbCfgRegFile_chk.sv
module smbCfgRegFile_chk #(
  parameter int NREG = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaDriveLow,
  input logic [NREG*8-1:0] cfgBytes,
  input logic              pciStopPinN,
  input logic              pciRunEff,
  input logic [6:0]        pllN,
  input logic [5:0]        pllR,
  input logic              wrEn
);

  // R10: SDA drive never moves while SCL has been high for a while
  p_sda_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn) && $past(sclIn, 2) && $past(sclIn, 3)) |-> $stable(sdaDriveLow));

  // R10: a register write follows an SCL high phase
  p_commit_after_rise_r10: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> ($past(sclIn) && $past(sclIn, 3)));

  // R3: stop pin low forces the run flag low
  p_run_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    !pciStopPinN |-> !pciRunEff);

  // R4: signature byte never changes
  p_sig_keep_r4: assert property (@(posedge clk) disable iff (!rstN)
    $stable(cfgBytes[55:48]));

  // R6: dividers move only when the register bytes move
  p_pll_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    $stable(cfgBytes) |-> ($stable(pllN) && $stable(pllR)));

endmodule

bind smbCfgRegFile smbCfgRegFile_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaDriveLow(sdaDriveLow),
  .cfgBytes(cfgBytes), .pciStopPinN(pciStopPinN), .pciRunEff(pciRunEff),
  .pllN(pllN), .pllR(pllR), .wrEn(regStb.wrEn)
);

// File: tb/smbCfgRegFile_tb.sv
module smbCfgRegFile_tb;

  localparam int NREG = 10;
  localparam int H    = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [1:0] freqSel = 2'b00;
  logic pciStopPinN = 1'b0;
  logic sdaDriveLow;
  logic [NREG*8-1:0] cfgBytes;
  logic pciRunEff;
  logic [6:0] pllN;
  logic [5:0] pllR;
  wire sdaBus = sdaM & ~sdaDriveLow;

  always #4 clk = ~clk;

  smbCfgRegFile u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .freqSel(freqSel), .pciStopPinN(pciStopPinN),
    .cfgBytes(cfgBytes), .pciRunEff(pciRunEff), .pllN(pllN), .pllR(pllR)
  );

  int total = 0;
  int bad = 0;
  bit cmpOn = 1'b0;
  bit finished = 1'b0;
  logic [7:0] mdl [NREG];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] maskOf(input int i);
    if (i == 0) return 8'hE8;
    if (i == 6) return 8'h00;
    return 8'hFF;
  endfunction

  function automatic void mdlReset();
    logic [7:0] d [10] = '{8'h09, 8'h87, 8'h7F, 8'hDF, 8'h3F, 8'h40, 8'h0D, 8'h00, 8'h00, 8'h00};
    for (int i = 0; i < NREG; i++) mdl[i] = d[i];
  endfunction

  function automatic void mdlWrite(input int i, input logic [7:0] b);
    if (i < NREG) mdl[i] = (mdl[i] & ~maskOf(i)) | (b & maskOf(i));
  endfunction

  function automatic logic [7:0] expRead(input int i);
    if (i >= NREG) return 8'h00;
    if (i == 0) return (mdl[0] & 8'hF1) | {4'b0, mdl[0][3] & pciStopPinN, freqSel, 1'b0};
    return mdl[i];
  endfunction

  // per-clock comparison against the reference model
  always @(negedge clk) begin
    if (rstN && cmpOn) begin
      logic [NREG*8-1:0] expCfg;
      logic sel;
      for (int i = 0; i < NREG; i++) expCfg[i*8 +: 8] = mdl[i];
      sel = mdl[9][0];
      chk("R10/R11 cfgBytes", 32'(cfgBytes[31:0] ^ expCfg[31:0]) | 32'(cfgBytes[79:32] != expCfg[79:32]), 32'd0);
      chk("R6 pll", {19'd0, pllN, pllR}, {19'd0, sel ? mdl[8][6:0] : 7'd48, sel ? mdl[9][6:1] : 6'd10});
      chk("R3 run", 32'(pciRunEff), 32'(mdl[0][3] & pciStopPinN));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(H);
    sclM = 1'b1; tick(H);
    sdaM = 1'b0; tick(H);
    sclM = 1'b0; tick(2);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(H);
    sclM = 1'b1; tick(H);
    sdaM = 1'b1; tick(H);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; tick(H);
    sclM = 1'b1; tick(H);
    sclM = 1'b0; tick(2);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit gate, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      if (i == 0 && gate) cmpOn = 1'b0;
      sendBit(b[i]);
    end
    sdaM = 1'b1; tick(H);
    sclM = 1'b1; tick(H/2);
    ack = !sdaBus;
    tick(H/2);
    sclM = 1'b0; tick(2);
  endtask

  task automatic recvByte(input bit mAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(H);
      sclM = 1'b1; tick(H/2);
      b = {b[6:0], sdaBus};
      tick(H/2);
      sclM = 1'b0; tick(2);
    end
    sdaM = !mAck; tick(H);
    sclM = 1'b1; tick(H);
    sclM = 1'b0; tick(2);
    sdaM = 1'b1;
  endtask

  task automatic wrHeader();
    bit ack;
    sendByte(8'hD2, 1'b0, ack); chk("R1 write address ack", 32'(ack), 32'd1);
    sendByte(8'h5A, 1'b0, ack); chk("R2 command ack", 32'(ack), 32'd1);
    sendByte(8'h0A, 1'b0, ack); chk("R2 count ack", 32'(ack), 32'd1);
  endtask

  task automatic wrData(input logic [7:0] q [$]);
    bit ack;
    for (int k = 0; k < q.size(); k++) begin
      sendByte(q[k], 1'b1, ack);
      chk(k >= NREG ? "R7 extra byte ack" : (k == 6 ? "R4 signature write ack" : "R2 data ack"),
          32'(ack), 32'd1);
      mdlWrite(k, q[k]);
      cmpOn = 1'b1;
    end
  endtask

  task automatic wrTxn(input logic [7:0] q [$]);
    busStart();
    wrHeader();
    wrData(q);
    busStop();
  endtask

  task automatic rdTxn(input int n);
    bit ack;
    logic [7:0] b;
    busStart();
    sendByte(8'hD3, 1'b0, ack); chk("R1 read address ack", 32'(ack), 32'd1);
    recvByte(1'b1, b); chk("R8 count byte", 32'(b), 32'h0A);
    for (int k = 0; k < n; k++) begin
      recvByte(k < n - 1, b);
      chk(k == 0 ? "R3 byte0 readback" : (k == 6 ? "R4 signature read" :
          (k >= NREG ? "R8 beyond range" : "R8 data byte")), 32'(b), 32'(expRead(k)));
    end
    busStop();
    chk("R8 released after NACK", 32'(sdaBus), 32'd1);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    bit ack;
    logic [7:0] q [$];
    mdlReset();
    tick(5);
    rstN = 1'b1;
    tick(5);
    chk("R5 reset bytes", 32'(cfgBytes[79:48] != {8'h00, 8'h00, 8'h00, 8'h0D}) |
        32'(cfgBytes[47:0] != {8'h40, 8'h3F, 8'hDF, 8'h7F, 8'h87, 8'h09}), 32'd0);
    chk("R5 sda idle", 32'(sdaDriveLow), 32'd0);
    cmpOn = 1'b1;
    rdTxn(11);

    // R1: foreign addresses
    busStart();
    sendByte(8'hA0, 1'b0, ack); chk("R1 foreign address nack", 32'(ack), 32'd0);
    sendByte(8'h00, 1'b0, ack); chk("R1 ignored after nack", 32'(ack), 32'd0);
    busStop();
    busStart();
    sendByte(8'hD4, 1'b0, ack); chk("R1 neighbour address nack", 32'(ack), 32'd0);
    busStop();

    // R2, R4, R6, R7: full write plus two extra bytes
    q = '{8'hA5, 8'h3C, 8'h12, 8'h80, 8'hFF, 8'h55, 8'h77, 8'h99, 8'h2B, 8'h5F, 8'hEE, 8'h11};
    wrTxn(q);
    chk("R6 pllN from register", 32'(pllN), 32'h2B);
    chk("R6 pllR from register", 32'(pllR), 32'h2F);
    freqSel = 2'b10;
    pciStopPinN = 1'b1;
    tick(2);
    rdTxn(12);

    // R3: set the stored stop bit, then drop the pin
    wrTxn('{8'h08});
    chk("R3 run with pin high", 32'(pciRunEff), 32'd1);
    freqSel = 2'b01;
    tick(2);
    rdTxn(1);
    pciStopPinN = 1'b0;
    tick(2);
    chk("R3 run with pin low", 32'(pciRunEff), 32'd0);
    rdTxn(1);
    pciStopPinN = 1'b1;

    // R9: START inside a byte
    busStart();
    wrHeader();
    wrData('{8'h28});
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b0);
    busStart();
    wrHeader();
    wrData('{8'h61});
    busStop();
    chk("R9 partial byte dropped", 32'(cfgBytes[15:8]), 32'h3C);
    rdTxn(3);

    // R9: STOP inside a byte
    busStart();
    wrHeader();
    wrData('{8'hE8});
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    busStop();
    chk("R9 completed byte kept", 32'(cfgBytes[7:0]), 32'(mdl[0]));
    rdTxn(2);

    // R6: back to built-in dividers
    wrTxn('{8'h08, 8'h87, 8'h7F, 8'hDF, 8'h3F, 8'h40, 8'h0D, 8'h00, 8'h44, 8'h00});
    chk("R6 pllN default", 32'(pllN), 32'd48);
    chk("R6 pllR default", 32'(pllR), 32'd10);

    // pin change while the byte 0 commit happens
    fork
      wrTxn('{8'hC0});
      begin tick(640); pciStopPinN = ~pciStopPinN; end
    join
    tick(4);
    chk("R3 run after collision", 32'(pciRunEff), 32'(mdl[0][3] & pciStopPinN));
    rdTxn(1);

    tick(10);
    finishRun();
  end

endmodule